// File: doc/BRIEF.md
# Branch Target Address Generator

This unit forms the destination address of a relative branch or subroutine call in a microcontroller core. Its base is always the address of the first byte of the instruction after the branch. It supports two target forms. The first is a signed short (8-bit) or long (16-bit) displacement, sign-extended and added to the base. The second is an index register of byte, word or longword size, zero-extended, doubled and added to the base. A 24-bit addressing mode clears the upper byte of the result after the addition.

The result is registered on one clock edge. A valid strobe travels with the operation. The unit reports two conditions and does not act on them: an odd target, with the address passed through unchanged, and a reserved mode code. Both are left for a later pipeline stage to handle. Decoding, condition testing, fetching and return-address stacking happen elsewhere.

Top module: `branch_target_gen`

## Requirements
- R1: With `modeSel`=00, `target` = `nextPc` + sign-extended `disp[7:0]`. From a 2-byte branch at `nextPc`-2, this reaches -126 to +129 bytes.
- R2: With `modeSel`=01, `target` = `nextPc` + sign-extended `disp[15:0]`.
- R3: With `modeSel`=10, `idxVal` is zero-extended from the size given by `idxSize` and then doubled before it is added to `nextPc`. The size codes are 00 = bits 7:0, 01 = bits 15:0, and 10 or 11 = all 32 bits. Bits above the selected size have no effect.
- R4: The addition wraps modulo 2^32 and gives no overflow indication.
- R5: When `addrMode24`=1, bits 31:24 of `target` are zero. Bits 23:0 equal the low 24 bits of the 32-bit sum.
- R6: `oddTarget` equals bit 0 of the registered `target`, and `target` is never adjusted to make it even.
- R7: With `modeSel`=11, `target` is `nextPc` (masked as in R5) and `illegalMode`=1. For the other three codes `illegalMode`=0.
- R8: Results appear one cycle after the inputs are presented: `validOut` is `validIn` delayed by one clock.
- R9: A cycle with `validIn`=0 leaves `target`, `oddTarget` and `illegalMode` unchanged.
- R10: A synchronous active-high `rst` clears `validOut`, `target`, `oddTarget` and `illegalMode` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| validIn | input | 1 | Operands present this cycle |
| addrMode24 | input | 1 | 1 = 24-bit addressing, 0 = full 32-bit |
| modeSel | input | 2 | 00 short disp, 01 long disp, 10 index, 11 reserved |
| idxSize | input | 2 | Index size: 00 byte, 01 word, 1x longword |
| nextPc | input | 32 | Address of the instruction after the branch |
| disp | input | 16 | Displacement; short form uses bits 7:0 |
| idxVal | input | 32 | Index register contents |
| validOut | output | 1 | Registered result valid |
| target | output | 32 | Branch target address |
| oddTarget | output | 1 | Target bit 0 is set |
| illegalMode | output | 1 | Reserved mode code was used |

## Verification
The wrap of the 32-bit addition and the 24-bit upper-byte clearing can act on the same operation. The order between them matters: masking applies to the wrapped sum. The bench provokes this case with a base near 2^32 and a positive long displacement, and with an all-ones longword index whose doubled value wraps past zero, both in 24-bit mode. The behavioural model computes the wide sum first, reduces it modulo 2^32 and only then masks it. A wrong order or a carry leaking into bit 24 therefore shows up as a miscompare. The odd flag and the reserved-mode flag also fall in one cycle when an odd base is used with code 11, and both are compared on that same cycle.

// File: rtl/bt_pkg.sv
package bt_pkg;

  typedef enum logic [1:0] {
    MODE_D8  = 2'b00,
    MODE_D16 = 2'b01,
    MODE_IDX = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_WORD = 2'b01,
    SZ_LONG = 2'b10,
    SZ_ALT  = 2'b11
  } size_e;

  localparam int LANES = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic             load;      // capture a new result
    logic             selShort;  // sign-extended short displacement
    logic             selLong;   // sign-extended long displacement
    logic             selIndex;  // doubled zero-extended index
    logic             selBase;   // reserved code: no offset
    logic             clipHigh;  // clear bits above the narrow width
    logic [LANES-1:0] idxLane;   // one-hot index size lane
  } strobe_t;

endpackage

// File: rtl/bt_ctrl.sv
module bt_ctrl
  import bt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       validIn,
  input  logic       addrMode24,
  input  logic [1:0] modeSel,
  input  logic [1:0] idxSize,
  output strobe_t    stb
);

  always_comb begin
    stb          = '0;
    stb.load     = validIn;
    stb.clipHigh = addrMode24;
    case (modeSel)
      MODE_D8:  stb.selShort = 1'b1;
      MODE_D16: stb.selLong  = 1'b1;
      MODE_IDX: stb.selIndex = 1'b1;
      default:  stb.selBase  = 1'b1;
    endcase
    case (idxSize)
      SZ_BYTE: stb.idxLane = 3'b001;
      SZ_WORD: stb.idxLane = 3'b010;
      default: stb.idxLane = 3'b100;
    endcase
  end

  // R7: exactly one offset source per cycle, reserved code included
  a_r7_one_source: assert property (@(posedge clk) disable iff (rst)
    $onehot({stb.selShort, stb.selLong, stb.selIndex, stb.selBase}));

  // R3: the size lane select is always a single lane
  a_r3_one_lane: assert property (@(posedge clk) disable iff (rst)
    $countones(stb.idxLane) == 1);

endmodule

// File: rtl/bt_datapath.sv
module bt_datapath
  import bt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int KEEP_W  = 24,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [LONG_W-1:0] disp,
  input  logic [ADDR_W-1:0] idxVal,
  output logic              validOut,
  output logic [ADDR_W-1:0] target,
  output logic              oddTarget,
  output logic              illegalMode
);

  localparam int SHORT_PAD = ADDR_W - SHORT_W;
  localparam int LONG_PAD  = ADDR_W - LONG_W;
  localparam int BYTE_PAD  = ADDR_W - BYTE_W;
  localparam int WORD_PAD  = ADDR_W - WORD_W;

  logic [ADDR_W-1:0] shortExt, longExt, idxZext, idxScaled;
  logic [ADDR_W-1:0] offset, rawSum, clipped;

  assign shortExt = {{SHORT_PAD{disp[SHORT_W-1]}}, disp[SHORT_W-1:0]};
  assign longExt  = {{LONG_PAD{disp[LONG_W-1]}}, disp};

  assign idxZext =
      ({ADDR_W{stb.idxLane[0]}} & {{BYTE_PAD{1'b0}}, idxVal[BYTE_W-1:0]})
    | ({ADDR_W{stb.idxLane[1]}} & {{WORD_PAD{1'b0}}, idxVal[WORD_W-1:0]})
    | ({ADDR_W{stb.idxLane[2]}} & idxVal);

  // doubling drops the top bit: modulo 2^ADDR_W
  assign idxScaled = {idxZext[ADDR_W-2:0], 1'b0};

  assign offset =
      ({ADDR_W{stb.selShort}} & shortExt)
    | ({ADDR_W{stb.selLong}}  & longExt)
    | ({ADDR_W{stb.selIndex}} & idxScaled);

  assign rawSum = nextPc + offset;

  generate
    if (KEEP_W < ADDR_W) begin : g_clip
      assign clipped = stb.clipHigh
                     ? {{(ADDR_W-KEEP_W){1'b0}}, rawSum[KEEP_W-1:0]}
                     : rawSum;

      // R5: narrow mode leaves the upper field clear
      a_r5_upper_clear: assert property (@(posedge clk) disable iff (rst)
        (stb.load && stb.clipHigh) |=> (target[ADDR_W-1:KEEP_W] == '0));
    end else begin : g_full
      assign clipped = rawSum;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      validOut    <= 1'b0;
      target      <= '0;
      oddTarget   <= 1'b0;
      illegalMode <= 1'b0;
    end else begin
      validOut <= stb.load;
      if (stb.load) begin
        target      <= clipped;
        oddTarget   <= clipped[0];
        illegalMode <= stb.selBase;
      end
    end
  end

  // R6: flag agrees with the registered address
  a_r6_odd_flag: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> (oddTarget == target[0]));

  // R3: a doubled index never changes the parity of the base
  a_r3_parity_kept: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.selIndex) |=> (target[0] == $past(nextPc[0])));

  // R7: reserved code yields the base and raises the flag
  a_r7_base_pass: assert property (@(posedge clk) disable iff (rst)
    (stb.load && stb.selBase && !stb.clipHigh) |=>
      (illegalMode && target == $past(nextPc)));

  // R8: one-cycle valid pipeline
  a_r8_valid_delay: assert property (@(posedge clk) disable iff (rst)
    stb.load |=> validOut);
  a_r8_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> !validOut);

  // R9: idle cycles hold the result
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !stb.load |=> ($stable(target) && $stable(oddTarget) && $stable(illegalMode)));

endmodule

// File: rtl/branch_target_gen.sv
module branch_target_gen
  import bt_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int KEEP_W  = 24,
  parameter int SHORT_W = 8,
  parameter int LONG_W  = 16,
  parameter int BYTE_W  = 8,
  parameter int WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              validIn,
  input  logic              addrMode24,
  input  logic [1:0]        modeSel,
  input  logic [1:0]        idxSize,
  input  logic [ADDR_W-1:0] nextPc,
  input  logic [LONG_W-1:0] disp,
  input  logic [ADDR_W-1:0] idxVal,
  output logic              validOut,
  output logic [ADDR_W-1:0] target,
  output logic              oddTarget,
  output logic              illegalMode
);

  strobe_t stb;

  bt_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .validIn    (validIn),
    .addrMode24 (addrMode24),
    .modeSel    (modeSel),
    .idxSize    (idxSize),
    .stb        (stb)
  );

  bt_datapath #(
    .ADDR_W  (ADDR_W),
    .KEEP_W  (KEEP_W),
    .SHORT_W (SHORT_W),
    .LONG_W  (LONG_W),
    .BYTE_W  (BYTE_W),
    .WORD_W  (WORD_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .nextPc      (nextPc),
    .disp        (disp),
    .idxVal      (idxVal),
    .validOut    (validOut),
    .target      (target),
    .oddTarget   (oddTarget),
    .illegalMode (illegalMode)
  );

endmodule

// File: tb/branch_target_gen_tb.sv
module branch_target_gen_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst, validIn, addrMode24;
  logic [1:0]  modeSel, idxSize;
  logic [31:0] nextPc, idxVal;
  logic [15:0] disp;
  logic        validOut, oddTarget, illegalMode;
  logic [31:0] target;

  int vectors = 0;
  int fails   = 0;

  // expected state after the next edge
  bit          expValid, expOdd, expIll;
  bit [31:0]   expTgt;
  string       expTag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_gen dut_i (
    .clk(clk), .rst(rst), .validIn(validIn), .addrMode24(addrMode24),
    .modeSel(modeSel), .idxSize(idxSize), .nextPc(nextPc), .disp(disp),
    .idxVal(idxVal), .validOut(validOut), .target(target),
    .oddTarget(oddTarget), .illegalMode(illegalMode)
  );

  function automatic void refModel(input bit [1:0] m, input bit [1:0] sz,
      input bit a24, input bit [31:0] pc, input bit [15:0] d, input bit [31:0] ix,
      output bit [31:0] tgt, output bit odd, output bit ill);
    longint off, sum;
    logic signed [7:0]  s8;
    logic signed [15:0] s16;
    s8 = d[7:0];
    s16 = d;
    case (m)
      2'd0: off = s8;
      2'd1: off = s16;
      2'd2: begin
        if (sz == 2'd0)      off = 2 * longint'(ix[7:0]);
        else if (sz == 2'd1) off = 2 * longint'(ix[15:0]);
        else                 off = 2 * longint'(ix);
      end
      default: off = 0;
    endcase
    sum = (longint'(pc) + off) % 64'sh1_0000_0000;
    if (sum < 0) sum = sum + 64'sh1_0000_0000;
    if (a24) sum = sum % 64'sh100_0000;
    tgt = sum[31:0];
    odd = tgt[0];
    ill = (m == 2'd3);
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkOuts();
    bit side;
    side = (expTag == "R9") || (expTag == "R10");
    cmp(side ? expTag : "R8", "validOut", {31'd0, validOut}, {31'd0, expValid});
    cmp(expTag, "target", target, expTgt);
    cmp(side ? expTag : "R6", "oddTarget", {31'd0, oddTarget}, {31'd0, expOdd});
    cmp(side ? expTag : "R7", "illegalMode", {31'd0, illegalMode}, {31'd0, expIll});
  endtask

  task automatic step(string tag, bit r, bit v, bit a24, bit [1:0] m,
      bit [1:0] sz, bit [31:0] pc, bit [15:0] d, bit [31:0] ix);
    @(negedge clk);
    checkOuts();
    rst = r; validIn = v; addrMode24 = a24; modeSel = m; idxSize = sz;
    nextPc = pc; disp = d; idxVal = ix;
    if (r) begin
      expValid = 0; expTgt = 0; expOdd = 0; expIll = 0; expTag = "R10";
    end else begin
      expValid = v;
      if (v) begin
        refModel(m, sz, a24, pc, d, ix, expTgt, expOdd, expIll);
        expTag = tag;
      end else begin
        expTag = "R9";
      end
    end
  endtask

  initial begin
    rst = 1; validIn = 1; addrMode24 = 0; modeSel = 0; idxSize = 0;
    nextPc = 32'hFFFF_FFFF; disp = 16'hFFFF; idxVal = '1;
    // R10: reset state
    step("R10", 1, 1, 1, 2'd3, 2'd2, 32'h1234_5677, 16'h7F, '1);
    step("R10", 1, 1, 0, 2'd0, 2'd0, 32'h0, 16'h0, '0);
    // R1: short displacement extremes
    step("R1", 0, 1, 0, 2'd0, 2'd0, 32'h0000_1000, 16'hAA7F, '0);
    step("R1", 0, 1, 0, 2'd0, 2'd0, 32'h0000_1000, 16'h0080, '0);
    step("R4", 0, 1, 0, 2'd0, 2'd0, 32'h0000_0002, 16'h0080, '0);
    // R2: long displacement extremes
    step("R2", 0, 1, 0, 2'd1, 2'd0, 32'h0010_0000, 16'h7FFF, '0);
    step("R2", 0, 1, 0, 2'd1, 2'd0, 32'h0010_0000, 16'h8000, '0);
    // R3: all-ones index at each size, upper bits ignored
    step("R3", 0, 1, 0, 2'd2, 2'd0, 32'h0000_4000, 16'h8000, 32'hFFFF_FFFF);
    step("R3", 0, 1, 0, 2'd2, 2'd1, 32'h0000_4000, 16'h0000, 32'hFFFF_FFFF);
    step("R3", 0, 1, 0, 2'd2, 2'd2, 32'h0000_4000, 16'h0000, 32'hFFFF_FFFF);
    step("R3", 0, 1, 0, 2'd2, 2'd3, 32'h0000_4000, 16'h0000, 32'h8000_0001);
    // R4: wrap past the top
    step("R4", 0, 1, 0, 2'd1, 2'd0, 32'hFFFF_FFF0, 16'h7FFF, '0);
    // R5: narrow mode, with wrap in the same operation
    step("R5", 0, 1, 1, 2'd1, 2'd0, 32'hFFFF_FFF0, 16'h7FFF, '0);
    step("R5", 0, 1, 1, 2'd0, 2'd0, 32'h00FF_FFFE, 16'h0008, '0);
    step("R5", 0, 1, 1, 2'd2, 2'd2, 32'h0000_0010, 16'h0000, 32'hFFFF_FFFF);
    step("R5", 0, 1, 1, 2'd1, 2'd0, 32'hAB12_3456, 16'h8000, '0);
    // R6: odd target passed through unchanged
    step("R6", 0, 1, 0, 2'd0, 2'd0, 32'h0000_2000, 16'h0001, '0);
    step("R6", 0, 1, 0, 2'd2, 2'd0, 32'h0000_2001, 16'h0000, 32'h0000_0003);
    // R7: reserved code, flag with odd base, both modes
    step("R7", 0, 1, 1, 2'd3, 2'd0, 32'hAB12_3457, 16'h7FFF, 32'hFFFF);
    step("R7", 0, 1, 0, 2'd3, 2'd2, 32'hAB12_3456, 16'h0001, 32'hFFFF);
    // R9: idle cycles with changing inputs hold the result
    step("R9", 0, 0, 0, 2'd0, 2'd0, 32'h5555_5555, 16'h0001, '0);
    step("R9", 0, 0, 1, 2'd2, 2'd1, 32'h0000_0000, 16'h8000, '1);
    // R8: back-to-back operations
    step("R8", 0, 1, 0, 2'd1, 2'd0, 32'h0000_0100, 16'h0010, '0);
    step("R8", 0, 1, 0, 2'd0, 2'd0, 32'h0000_0200, 16'h00F0, '0);
    step("R9", 0, 0, 0, 2'd1, 2'd0, 32'h0000_0300, 16'h0002, '0);
    // R10: reset in mid-stream
    step("R10", 1, 1, 0, 2'd0, 2'd0, 32'h0000_0301, 16'h0001, '0);
    // mixed traffic
    for (int i = 0; i < 200; i++) begin
      bit [31:0] a = $urandom;
      bit [31:0] b = $urandom;
      bit [31:0] c = $urandom;
      string t;
      case (a[1:0])
        2'd0: t = "R1";
        2'd1: t = "R2";
        2'd2: t = "R3";
        default: t = "R7";
      endcase
      if (a[3]) t = "R5";
      step(t, 0, a[2] | a[4], a[3], a[1:0], a[6:5], b, c[15:0], {c[7:0], b[31:8]});
    end
    step("R9", 0, 0, 0, 2'd0, 2'd0, 32'h0, 16'h0, '0);
    @(negedge clk);
    checkOuts();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule